// File: doc/BRIEF.md
# Latency-Aware Programmable Priority Arbiter

This block decides which of four initiators may use a shared memory target next. The four are a PCI bridge, an external memory port initiator, a general purpose DMA engine and a CPU buffer. Each initiator raises its request line and holds it. The arbiter grants one of them at a time. The grant stays until the granted initiator pulses its transfer-done line. Software sets each initiator's 2-bit priority through a small write port. It also sets a starvation latency value for each of the three non-CPU initiators, and one register holds their latency enable bits.

A two-state machine controls the grant. In `ST_IDLE` no grant is active. On any request, the *award* transition registers a one-hot grant and moves to `ST_GRANT`. In `ST_GRANT` the grant is frozen. A done pulse from the granted initiator takes the *release* transition back to `ST_IDLE`, and the grant clears. When no request is pending, `ST_IDLE` stays in `ST_IDLE`. When done has not arrived, `ST_GRANT` stays in `ST_GRANT`.

A non-CPU initiator can have its latency check enabled. While such an initiator waits, its counter counts down. Once the counter is empty, that initiator wins over every initiator whose counter has not run out. The CPU buffer has no counter. It still takes part in every decision, so a lone CPU request is always served and the node cannot deadlock.

Top module: `lat_prio_arb`

## Requirements
- R1: After reset `gnt_o` is 0, all latency checks are off, the priorities are PCI=0, EMP=1, DMA=2, CPU=3, and every latency value is `LAT_RST`. Initiator index 0 is PCI, 1 is EMP, 2 is DMA and 3 is CPU, in both `req_i` and `gnt_o`.
- R2: `gnt_o` has at most one bit set. A grant bit rises only for an initiator whose request was high in the cycle of the decision.
- R3: Writes use `cfg_we`, `cfg_addr` and `cfg_wdata`. Address 0 sets the latency enables from bit 0 (PCI), bit 1 (EMP) and bit 2 (DMA). Address 1 sets the CPU priority from bits [1:0]. Addresses 2, 3 and 4 set PCI, EMP and DMA: priority from bits [1:0] and latency value from bits [15:8].
- R4: With no expired counter, the winner is the requester with the smallest priority value. Equal values go to the lower initiator index.
- R5: An enabled non-CPU initiator that is requesting and not granted decrements its counter each cycle, down to 0. A requesting enabled initiator whose counter is 0 is expired. If any initiator is expired, the winner is chosen among the expired ones only, using the R4 rule.
- R6: A counter reloads its programmed latency value in any cycle where its initiator is granted, is not requesting, or has its check disabled.
- R7: The CPU buffer never expires. It wins whenever it is the sole requester, or whenever nothing is expired and it has the best priority.
- R8: A grant is held until the granted initiator's `done_i` bit is high. It then clears at the next edge. Done bits of initiators that are not granted have no effect.
- R9: A decision is made only in `ST_IDLE`, and its grant appears on `gnt_o` after one clock edge.
- R10: A configuration write made while a grant is active leaves that grant unchanged and is used at the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Request per initiator (0 PCI, 1 EMP, 2 DMA, 3 CPU) |
| done_i | input | 4 | Transfer-done pulse per initiator |
| gnt_o | output | 4 | One-hot registered grant |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |

## Verification
The assertions take two things for granted. Requests are level signals that may drop at any time. Done pulses can arrive on any initiator, not only the granted one. For that reason the hold and release properties only look at the done bit of the granted initiator.

The stimulus exercises these cases:
- Random requesters raise requests and sometimes withdraw them.
- A granted initiator holds its grant for one to four cycles and then pulses done.
- Stray done pulses are injected on ungranted initiators.
- Random configuration writes use small latency values, so counters expire often.

A cycle-level model in the bench, built from the requirements, predicts every grant.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int N_INIT = 4;
    localparam int N_LAT  = 3;
    localparam int PRIO_W = 2;
    localparam int IDX_W  = $clog2(N_INIT);
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int LAT_LSB = 8;

    localparam logic [ADDR_W-1:0] A_LAT_EN  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CPU_PRI = 3'd1;
    localparam logic [ADDR_W-1:0] A_PCI     = 3'd2;
    localparam logic [ADDR_W-1:0] A_EMP     = 3'd3;
    localparam logic [ADDR_W-1:0] A_DMA     = 3'd4;

    typedef enum logic {
        ST_IDLE,
        ST_GRANT
    } arb_state_e;
endpackage

// File: rtl/arb_cfg.sv
module arb_cfg
    import arb_pkg::*;
#(
    parameter int LAT_W = 8,
    parameter logic [LAT_W-1:0] LAT_RST = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [ADDR_W-1:0]                  cfg_addr,
    input  logic [DATA_W-1:0]                  cfg_wdata,
    output logic [N_LAT-1:0]                   lat_en,
    output logic [N_INIT-1:0][PRIO_W-1:0]      prio,
    output logic [N_LAT-1:0][LAT_W-1:0]        lat_val
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_en <= '0;
            for (int i = 0; i < N_INIT; i++) prio[i] <= PRIO_W'(i);
            for (int i = 0; i < N_LAT; i++) lat_val[i] <= LAT_RST;
        end else if (cfg_we) begin
            case (cfg_addr)
                A_LAT_EN:  lat_en <= cfg_wdata[N_LAT-1:0];
                A_CPU_PRI: prio[N_INIT-1] <= cfg_wdata[PRIO_W-1:0];
                A_PCI, A_EMP, A_DMA: begin
                    prio[cfg_addr - A_PCI]    <= cfg_wdata[PRIO_W-1:0];
                    lat_val[cfg_addr - A_PCI] <= cfg_wdata[LAT_LSB +: LAT_W];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/arb_lat_ctr.sv
module arb_lat_ctr #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             req,
    input  logic             gnt,
    input  logic [LAT_W-1:0] val,
    output logic             expired
);
    logic [LAT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (!en || !req || gnt) cnt_q <= val;
        else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    assign expired = en && req && (cnt_q == '0);

    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !req || gnt) |=> cnt_q == $past(val));
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (en && req && !gnt && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
(
    input  logic [N_INIT-1:0]              req,
    input  logic [N_LAT-1:0]               expired,
    input  logic [N_INIT-1:0][PRIO_W-1:0]  prio,
    output logic [IDX_W-1:0]               win_idx,
    output logic                           win_vld
);
    logic [N_INIT-1:0] exp_ext;
    logic [N_INIT-1:0] cand;
    logic [PRIO_W-1:0] best_p;

    assign exp_ext = {{(N_INIT-N_LAT){1'b0}}, expired};
    assign cand    = (|expired) ? exp_ext : req;

    always_comb begin
        win_idx = '0;
        win_vld = 1'b0;
        best_p  = '1;
        for (int i = 0; i < N_INIT; i++) begin
            if (cand[i] && (!win_vld || prio[i] < best_p)) begin
                win_idx = IDX_W'(i);
                best_p  = prio[i];
                win_vld = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lat_prio_arb.sv
module lat_prio_arb
    import arb_pkg::*;
#(
    parameter int LAT_W = 8,
    parameter logic [LAT_W-1:0] LAT_RST = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  req_i,
    input  logic [3:0]  done_i,
    output logic [3:0]  gnt_o,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [15:0] cfg_wdata
);
    logic [N_LAT-1:0]              lat_en;
    logic [N_INIT-1:0][PRIO_W-1:0] prio;
    logic [N_LAT-1:0][LAT_W-1:0]   lat_val;
    logic [N_LAT-1:0]              expired;
    logic [IDX_W-1:0]              win_idx;
    logic                          win_vld;
    logic [N_INIT-1:0]             gnt_q;
    logic                          release_w;
    arb_state_e                    state_q, state_d;

    arb_cfg #(.LAT_W(LAT_W), .LAT_RST(LAT_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .lat_en(lat_en), .prio(prio), .lat_val(lat_val)
    );

    for (genvar g = 0; g < N_LAT; g++) begin : g_ctr
        arb_lat_ctr #(.LAT_W(LAT_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .en(lat_en[g]), .req(req_i[g]),
            .gnt(gnt_q[g]), .val(lat_val[g]), .expired(expired[g])
        );
    end

    arb_pick u_pick (
        .req(req_i), .expired(expired), .prio(prio),
        .win_idx(win_idx), .win_vld(win_vld)
    );

    assign release_w = |(done_i & gnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (win_vld)   state_d = ST_GRANT;   // award
            ST_GRANT: if (release_w) state_d = ST_IDLE;    // release
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (win_vld)   gnt_q <= N_INIT'(1) << win_idx;
                ST_GRANT: if (release_w) gnt_q <= '0;
                default:  gnt_q <= '0;
            endcase
        end
    end

    assign gnt_o = gnt_q;

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_q));
    a_r2_gnt_to_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && win_vld) |=> (gnt_q & $past(req_i)) != '0);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_q != '0 && (done_i & gnt_q) == '0) |=> gnt_q == $past(gnt_q));
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_i & gnt_q) != '0) |=> gnt_q == '0);
    a_r9_state_match: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRANT) == (gnt_q != '0));
endmodule

// File: tb/test_lat_prio_arb.sv
module test_lat_prio_arb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  req = 0, done = 0, gnt;
    logic        cfg_we = 0;
    logic [2:0]  cfg_addr = 0;
    logic [15:0] cfg_wdata = 0;
    int n_chk = 0, n_fail = 0;
    int unsigned seed = 32'h1234;

    always #10 clk = ~clk;

    lat_prio_arb i_lat_prio_arb (
        .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done), .gnt_o(gnt),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
    );

    // reference model built from the requirements
    logic [3:0]       m_gnt;
    logic [2:0]       m_en;
    logic [1:0]       m_pri [4];
    logic [7:0]       m_val [3];
    logic [7:0]       m_cnt [3];

    function automatic logic [3:0] pick(logic [3:0] r, logic [2:0] ex,
                                        logic [1:0] p0, logic [1:0] p1,
                                        logic [1:0] p2, logic [1:0] p3);
        logic [1:0] pv [4];
        logic [3:0] c;
        logic [3:0] w = 0;
        int best = 9;
        pv[0] = p0; pv[1] = p1; pv[2] = p2; pv[3] = p3;
        c = (ex != 0) ? {1'b0, ex} : r;
        for (int i = 0; i < 4; i++)
            if (c[i] && int'(pv[i]) < best) begin best = int'(pv[i]); w = 4'b1 << i; end
        return w;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_gnt = 0; m_en = 0;
            for (int i = 0; i < 4; i++) m_pri[i] = 2'(i);
            for (int i = 0; i < 3; i++) begin m_val[i] = 16; m_cnt[i] = 0; end
        end else begin
            logic [2:0] ex;
            logic [3:0] ng;
            for (int i = 0; i < 3; i++) ex[i] = m_en[i] && req[i] && m_cnt[i] == 0;
            ng = m_gnt;
            if (m_gnt == 0) ng = pick(req, ex, m_pri[0], m_pri[1], m_pri[2], m_pri[3]);
            else if ((done & m_gnt) != 0) ng = 0;
            for (int i = 0; i < 3; i++) begin
                if (!m_en[i] || !req[i] || m_gnt[i]) m_cnt[i] = m_val[i];
                else if (m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
            end
            m_gnt = ng;
            if (cfg_we) begin
                if (cfg_addr == 0) m_en = cfg_wdata[2:0];
                else if (cfg_addr == 1) m_pri[3] = cfg_wdata[1:0];
                else if (cfg_addr >= 2 && cfg_addr <= 4) begin
                    m_pri[cfg_addr-2] = cfg_wdata[1:0];
                    m_val[cfg_addr-2] = cfg_wdata[15:8];
                end
            end
        end
    end

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s gnt actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d; tick(); cfg_we = 0;
    endtask

    task automatic wait_gnt();
        for (int k = 0; k < 20 && gnt == 0; k++) tick();
    endtask

    task automatic finish_gnt(logic [3:0] keep);
        logic [3:0] g = gnt;
        done = g; req = (req & ~g) | (g & keep); tick(); done = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] hold [4];
        void'($urandom(seed));
        repeat (3) tick();
        check("R1 reset", gnt, 4'b0000);
        rst_n = 1; tick();
        check("R1 idle after reset", gnt, 4'b0000);

        req = 4'b1111; wait_gnt();
        check("R1 default order PCI", gnt, 4'b0001);
        done = 4'b0110; tick(); done = 0;
        check("R8 stray done ignored", gnt, 4'b0001);
        finish_gnt(0); wait_gnt();
        check("R4 EMP second", gnt, 4'b0010);
        finish_gnt(0); wait_gnt();
        check("R4 DMA third", gnt, 4'b0100);
        finish_gnt(0); wait_gnt();
        check("R7 CPU sole requester", gnt, 4'b1000);
        finish_gnt(0); tick();
        check("R9 idle when no request", gnt, 4'b0000);

        wr(1, 16'h0000); wr(4, 16'h1001); wr(3, 16'h1002); wr(2, 16'h1001);
        req = 4'b1111; wait_gnt();
        check("R3 R4 CPU programmed top", gnt, 4'b1000);
        finish_gnt(0); wait_gnt();
        check("R4 tie to lower index", gnt, 4'b0001);
        wr(3, 16'h1000);
        check("R10 write during grant keeps grant", gnt, 4'b0001);
        finish_gnt(0); wait_gnt();
        check("R10 new priority used", gnt, 4'b0010);
        finish_gnt(0);
        req = 0; tick(); tick();

        wr(2, 16'h1000); wr(3, 16'h1001); wr(4, 16'h0302); wr(1, 16'h0003);
        wr(0, 16'h0004);
        req = 4'b0111; wait_gnt();
        check("R5 PCI first before expiry", gnt, 4'b0001);
        repeat (8) tick();
        finish_gnt(4'b0001); wait_gnt();
        check("R5 expired DMA promoted", gnt, 4'b0100);
        wr(4, 16'h1402);
        finish_gnt(4'b0100); wait_gnt();
        check("R6 PCI after reload", gnt, 4'b0001);
        repeat (4) tick();
        finish_gnt(0); wait_gnt();
        check("R6 DMA not expired, EMP wins", gnt, 4'b0010);
        finish_gnt(0); req = 0; tick(); tick();

        for (int i = 0; i < 4; i++) hold[i] = 0;
        for (int c = 0; c < 4000; c++) begin
            check("R2 R4 R5 R6 R8 model", gnt, m_gnt);
            done = 0;
            cfg_we = 0;
            if ($urandom % 40 == 0) begin
                cfg_we = 1; cfg_addr = 3'($urandom % 5);
                cfg_wdata = {8'($urandom % 8), 8'($urandom % 8)};
            end
            for (int i = 0; i < 4; i++) begin
                if (gnt[i]) begin
                    if (hold[i] == 0) begin
                        done[i] = 1; req[i] = 1'($urandom % 2); hold[i] = 4'($urandom % 4);
                    end else hold[i] = hold[i] - 1;
                end else begin
                    if ($urandom % 16 == 0) done[i] = 1;
                    if (req[i]) begin
                        if (i < 3 && $urandom % 20 == 0) req[i] = 0;
                    end else if ($urandom % 4 == 0) req[i] = 1;
                end
            end
            tick();
        end
        cfg_we = 0; done = 0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule